// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the control core of a boundary-scan port. It runs the sixteen-state test access port state machine from the test clock and mode-select inputs. It also holds the instruction path: a serial instruction shifter and the parallel instruction that is in force. The serial data output is presented as a value plus an output enable, so the pad driver outside the block can build the three-state pin. Both change only on the falling edge of the test clock.

Three instructions are decoded:

- **SAMPLE/PRELOAD** places the external boundary chain between the serial input and output and leaves the pins in functional mode.
- **EXTEST** places the same chain in the path and also asserts a mode flag, so the pads take their values from the chain's update stage.
- **BYPASS** places a one-bit register in the path. Any opcode the block does not recognise does the same.

The boundary chain itself lives outside this block. The block feeds it the serial input and receives its serial return. It also gives the chain capture, shift and update strobes that follow the data-register states.

Top module: `scan_tap`

## Requirements
- R1: While `tap_rst` is high, and at once when it rises, the controller is in Test-Logic-Reset (`tap_state` = 0), `ir_value` is BYPASS (4'b1111), and `tdo_en` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high leave the controller in Test-Logic-Reset, from any starting state.
- R3: State changes on the rising edge of `tck` follow the standard test-access-port graph, driven by `tms`. `tap_state` uses this encoding:
  - 0: Test-Logic-Reset
  - 1: Run-Test/Idle
  - 2: Select-DR
  - 3: Capture-DR
  - 4: Shift-DR
  - 5: Exit1-DR
  - 6: Pause-DR
  - 7: Exit2-DR
  - 8: Update-DR
  - 9: Select-IR
  - 10: Capture-IR
  - 11: Shift-IR
  - 12: Exit1-IR
  - 13: Pause-IR
  - 14: Exit2-IR
  - 15: Update-IR
- R4: `tdo_en` changes only on a falling `tck` edge. After that edge it is 1 exactly when the state is Shift-IR (11) or Shift-DR (4).
- R5: Capture-IR loads 4'b0001 into the instruction shifter (binary 01 in the two low bits). In Shift-IR, each falling edge puts the shifter's bit 0 on `tdo`. Each rising edge shifts right and enters `tdi` at bit 3. This includes the edge that moves the controller to Exit1-IR.
- R6: `ir_value` changes only on the falling `tck` edge in Update-IR or Test-Logic-Reset. Shifting a new opcode leaves it unchanged until Update-IR.
- R7: Opcode 4'b0000 (EXTEST) gives `sel_bsr`=1 and `extest_mode`=1. Opcode 4'b0001 (SAMPLE/PRELOAD) gives `sel_bsr`=1 and `extest_mode`=0. Every other code, including 4'b1111 (BYPASS), gives `sel_bsr`=0 and `extest_mode`=0.
- R8: With `sel_bsr`=0, the bypass bit loads 0 on the rising edge in Capture-DR and loads `tdi` on each rising edge in Shift-DR. In Shift-DR, each falling edge drives the bypass bit onto `tdo`.
- R9: With `sel_bsr`=1, each falling edge in Shift-DR drives `chain_ret` onto `tdo`. `chain_si` always carries `tdi` to the external chain.
- R10: `dr_capture`, `dr_shift` and `dr_update` are high exactly while the state is Capture-DR, Shift-DR and Update-DR respectively.
- R11: Reaching Test-Logic-Reset through `tms` loads BYPASS (4'b1111) into `ir_value` on the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Asynchronous active-high reset to Test-Logic-Reset |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| chain_ret | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial test data out, changes on falling `tck` |
| tdo_en | output | 1 | Output enable for the three-state `tdo` pad |
| chain_si | output | 1 | Serial data into the external boundary chain |
| dr_capture | output | 1 | Data-register capture strobe |
| dr_shift | output | 1 | Data-register shift strobe |
| dr_update | output | 1 | Data-register update strobe |
| sel_bsr | output | 1 | Boundary chain is the selected data register |
| extest_mode | output | 1 | Pads are driven from the chain's update stage |
| ir_value | output | IR_W | Instruction currently in force |
| tap_state | output | 4 | Current controller state |

## Verification
The state is visible on `tap_state`, so a wrong transition shows on the very next sample after the rising edge that caused it. A corrupted instruction shifter shows on `tdo` within the same Shift-IR pass, because the captured 0001 pattern is read back first. After the following Update-IR it also shows on `ir_value` and the selects. A fault in the bypass bit or the output mux shows one half-cycle later, on the falling edge in Shift-DR. A fault in enable timing shows on the first falling edge after a shift state is entered or left.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  localparam int STATE_W = 4;

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       tap_rst,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge tap_rst) begin
    if (tap_rst) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
  import scan_tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = '0,
  parameter logic [IR_W-1:0] OP_SAMPLE = {{(IR_W-1){1'b0}}, 1'b1},
  parameter logic [IR_W-1:0] OP_BYPASS = '1
)(
  input  logic            tck,
  input  logic            tap_rst,
  input  logic            tdi,
  input  tap_state_e      state_q,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_value,
  output logic            sel_bsr,
  output logic            extest_mode
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] shift_q;

  // Serial instruction path, rising edge
  always_ff @(posedge tck or posedge tap_rst) begin
    if (tap_rst) begin
      shift_q <= CAP_PAT;
    end else if (state_q == ST_CAP_IR) begin
      shift_q <= CAP_PAT;
    end else if (state_q == ST_SH_IR) begin
      shift_q <= {tdi, shift_q[IR_W-1:1]};
    end
  end

  // Instruction in force, falling edge
  always_ff @(negedge tck or posedge tap_rst) begin
    if (tap_rst) begin
      ir_value <= OP_BYPASS;
    end else if (state_q == ST_RESET) begin
      ir_value <= OP_BYPASS;
    end else if (state_q == ST_UPD_IR) begin
      ir_value <= shift_q;
    end
  end

  assign ir_lsb      = shift_q[0];
  assign extest_mode = (ir_value == OP_EXTEST);
  assign sel_bsr     = (ir_value == OP_EXTEST) || (ir_value == OP_SAMPLE);

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       tap_rst,
  input  logic       tdi,
  input  tap_state_e state_q,
  input  logic       sel_bsr,
  input  logic       ir_lsb,
  input  logic       chain_ret,
  output logic       tdo,
  output logic       tdo_en
);

  logic byp_q;

  always_ff @(posedge tck or posedge tap_rst) begin
    if (tap_rst) begin
      byp_q <= 1'b0;
    end else if (!sel_bsr) begin
      if (state_q == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state_q == ST_SH_DR) byp_q <= tdi;
    end
  end

  always_ff @(negedge tck or posedge tap_rst) begin
    if (tap_rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
      if (state_q == ST_SH_IR)     tdo <= ir_lsb;
      else if (state_q == ST_SH_DR) tdo <= sel_bsr ? chain_ret : byp_q;
    end
  end

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = '0,
  parameter logic [IR_W-1:0] OP_SAMPLE = {{(IR_W-1){1'b0}}, 1'b1},
  parameter logic [IR_W-1:0] OP_BYPASS = '1
)(
  input  logic                tck,
  input  logic                tap_rst,
  input  logic                tms,
  input  logic                tdi,
  input  logic                chain_ret,
  output logic                tdo,
  output logic                tdo_en,
  output logic                chain_si,
  output logic                dr_capture,
  output logic                dr_shift,
  output logic                dr_update,
  output logic                sel_bsr,
  output logic                extest_mode,
  output logic [IR_W-1:0]     ir_value,
  output logic [STATE_W-1:0]  tap_state
);

  tap_state_e state_q;
  logic       ir_lsb;

  scan_tap_fsm u_fsm (
    .tck     (tck),
    .tap_rst (tap_rst),
    .tms     (tms),
    .state_q (state_q)
  );

  scan_tap_ir #(
    .IR_W      (IR_W),
    .OP_EXTEST (OP_EXTEST),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_BYPASS (OP_BYPASS)
  ) u_ir (
    .tck         (tck),
    .tap_rst     (tap_rst),
    .tdi         (tdi),
    .state_q     (state_q),
    .ir_lsb      (ir_lsb),
    .ir_value    (ir_value),
    .sel_bsr     (sel_bsr),
    .extest_mode (extest_mode)
  );

  scan_tap_dr u_dr (
    .tck       (tck),
    .tap_rst   (tap_rst),
    .tdi       (tdi),
    .state_q   (state_q),
    .sel_bsr   (sel_bsr),
    .ir_lsb    (ir_lsb),
    .chain_ret (chain_ret),
    .tdo       (tdo),
    .tdo_en    (tdo_en)
  );

  assign tap_state  = state_q;
  assign chain_si   = tdi;
  assign dr_capture = (state_q == ST_CAP_DR);
  assign dr_shift   = (state_q == ST_SH_DR);
  assign dr_update  = (state_q == ST_UPD_DR);

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk #(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_BYPASS = '1
)(
  input logic            tck,
  input logic            tap_rst,
  input logic            tms,
  input logic            tdo_en,
  input logic            dr_capture,
  input logic [IR_W-1:0] ir_value,
  input logic [3:0]      tap_state
);

  logic [2:0] ones_q;

  always_ff @(posedge tck or posedge tap_rst) begin
    if (tap_rst)     ones_q <= '0;
    else if (!tms)   ones_q <= '0;
    else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (tap_rst)
    (ones_q >= 3'd5) |-> (tap_state == 4'd0)); // R2

  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (tap_rst)
    tdo_en == ((tap_state == 4'd11) || (tap_state == 4'd4))); // R4

  AST_IR_HELD: assert property (@(posedge tck) disable iff (tap_rst)
    ((tap_state != 4'd15) && (tap_state != 4'd0)) |-> (ir_value == $past(ir_value))); // R6

  AST_RESET_BYPASS: assert property (@(posedge tck) disable iff (tap_rst)
    (tap_state == 4'd0) |-> (ir_value == OP_BYPASS)); // R11

  AST_CAPTURE_NEXT: assert property (@(posedge tck) disable iff (tap_rst)
    dr_capture |=> ((tap_state == 4'd4) || (tap_state == 4'd5))); // R10

endmodule

bind scan_tap scan_tap_chk #(.IR_W(IR_W), .OP_BYPASS(OP_BYPASS)) chk_i (
  .tck        (tck),
  .tap_rst    (tap_rst),
  .tms        (tms),
  .tdo_en     (tdo_en),
  .dr_capture (dr_capture),
  .ir_value   (ir_value),
  .tap_state  (tap_state)
);

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/1ps
module scan_tap_tb_top;

  localparam int IR_W = 4;
  localparam logic [3:0] OPX = 4'b0000;
  localparam logic [3:0] OPS = 4'b0001;
  localparam logic [3:0] OPB = 4'b1111;

  logic tck = 1'b0;
  logic tap_rst = 1'b1;
  logic tms = 1'b1, tdi = 1'b0, chain_ret = 1'b0;
  logic tdo, tdo_en, chain_si, dr_capture, dr_shift, dr_update, sel_bsr, extest_mode;
  logic [IR_W-1:0] ir_value;
  logic [3:0] tap_state;

  int n_checks = 0;
  int n_fail = 0;

  // model
  logic [3:0] m_state;
  logic [3:0] m_irsr;
  logic [3:0] m_ir;
  logic       m_byp;
  logic       m_tdo;
  logic       m_en;
  logic [3:0] shir_seen;
  int         shir_idx;

  always #2.5 tck = ~tck;

  scan_tap dut_i (
    .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .chain_ret(chain_ret),
    .tdo(tdo), .tdo_en(tdo_en), .chain_si(chain_si), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .sel_bsr(sel_bsr),
    .extest_mode(extest_mode), .ir_value(ir_value), .tap_state(tap_state)
  );

  function automatic logic [3:0] next_st(input logic [3:0] s, input logic t);
    case (s)
      4'd0:  return t ? 4'd0  : 4'd1;
      4'd1:  return t ? 4'd2  : 4'd1;
      4'd2:  return t ? 4'd9  : 4'd3;
      4'd3:  return t ? 4'd5  : 4'd4;
      4'd4:  return t ? 4'd5  : 4'd4;
      4'd5:  return t ? 4'd8  : 4'd6;
      4'd6:  return t ? 4'd7  : 4'd6;
      4'd7:  return t ? 4'd8  : 4'd4;
      4'd8:  return t ? 4'd2  : 4'd1;
      4'd9:  return t ? 4'd0  : 4'd10;
      4'd10: return t ? 4'd12 : 4'd11;
      4'd11: return t ? 4'd12 : 4'd11;
      4'd12: return t ? 4'd15 : 4'd13;
      4'd13: return t ? 4'd14 : 4'd13;
      4'd14: return t ? 4'd15 : 4'd11;
      default: return t ? 4'd2 : 4'd1;
    endcase
  endfunction

  function automatic logic m_sel(input logic [3:0] ir);
    return (ir == OPX) || (ir == OPS);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 tap_state", {4'd0, tap_state}, {4'd0, m_state});
    check("R4 tdo_en", {7'd0, tdo_en}, {7'd0, m_en});
    if (m_en) begin
      if (m_state == 4'd11)    check("R5 tdo in Shift-IR", {7'd0, tdo}, {7'd0, m_tdo});
      else if (m_sel(m_ir))    check("R9 tdo from chain", {7'd0, tdo}, {7'd0, m_tdo});
      else                     check("R8 tdo from bypass", {7'd0, tdo}, {7'd0, m_tdo});
    end
    check("R6 ir_value", {4'd0, ir_value}, {4'd0, m_ir});
    check("R7 selects", {6'd0, sel_bsr, extest_mode}, {6'd0, m_sel(m_ir), m_ir == OPX});
    check("R10 strobes", {5'd0, dr_capture, dr_shift, dr_update},
          {5'd0, m_state == 4'd3, m_state == 4'd4, m_state == 4'd8});
    check("R9 chain_si", {7'd0, chain_si}, {7'd0, tdi});
  endtask

  // called just after a falling edge
  task automatic step(input logic b_tms, input logic b_tdi, input logic b_ret);
    tms = b_tms; tdi = b_tdi; chain_ret = b_ret;
    @(posedge tck);
    case (m_state)
      4'd10: m_irsr = 4'b0001;
      4'd11: m_irsr = {tdi, m_irsr[3:1]};
      4'd3:  if (!m_sel(m_ir)) m_byp = 1'b0;
      4'd4:  if (!m_sel(m_ir)) m_byp = tdi;
      default: ;
    endcase
    m_state = next_st(m_state, tms);
    @(negedge tck);
    m_en = (m_state == 4'd11) || (m_state == 4'd4);
    if (m_state == 4'd11)     m_tdo = m_irsr[0];
    else if (m_state == 4'd4) m_tdo = m_sel(m_ir) ? chain_ret : m_byp;
    if (m_state == 4'd15) m_ir = m_irsr;
    if (m_state == 4'd0)  m_ir = OPB;
    #1;
    if (m_state == 4'd11 && shir_idx < 4) begin
      shir_seen[shir_idx] = tdo;
      shir_idx++;
    end
    compare_all();
  endtask

  task automatic do_reset();
    tap_rst = 1'b1;
    repeat (2) @(negedge tck);
    #1;
    m_state = 4'd0; m_irsr = 4'b0001; m_ir = OPB; m_byp = 1'b0; m_en = 1'b0; m_tdo = 1'b0;
    check("R1 reset state", {4'd0, tap_state}, 8'd0);
    check("R1 reset ir", {4'd0, ir_value}, {4'd0, OPB});
    check("R1 reset tdo_en", {7'd0, tdo_en}, 8'd0);
    tap_rst = 1'b0;
  endtask

  task automatic load_ir(input logic [3:0] op);
    repeat (5) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    shir_idx = 0;
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(i == 3, op[i], 1'b0);
    check("R5 captured pattern read back", {4'd0, shir_seen}, 8'h01);
    check("R6 ir held before update", {4'd0, ir_value}, {4'd0, m_ir});
    step(1'b1, 1'b0, 1'b0);
    check("R6 ir after Update-IR", {4'd0, ir_value}, {4'd0, op});
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int len);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < len; i++) step(i == len - 1, 1'($urandom), 1'($urandom));
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #500000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [3:0] ops [4];
    void'($urandom(32'h1149));
    m_state = 4'd0; m_irsr = 4'b0001; m_ir = OPB; m_byp = 1'b0; m_en = 1'b0; m_tdo = 1'b0;
    shir_seen = '0; shir_idx = 4;
    do_reset();

    // directed: each opcode, then a data scan
    load_ir(OPS);   scan_dr(6);
    load_ir(OPX);   scan_dr(6);
    load_ir(OPB);   scan_dr(6);
    load_ir(4'b0110); scan_dr(5);  // unrecognised -> bypass (R7)

    // R2 from a deep state: go to Pause-DR then five ones
    step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b0, 1'b0);
    check("R2 five ones reach reset", {4'd0, tap_state}, 8'd0);
    check("R11 reset loads bypass", {4'd0, ir_value}, {4'd0, OPB});

    ops[0] = OPX; ops[1] = OPS; ops[2] = OPB; ops[3] = 4'b1010;
    for (int blk = 0; blk < 20; blk++) begin
      logic [3:0] op;
      op = ops[$urandom % 4];
      if (blk % 5 == 4) op = 4'($urandom);
      load_ir(op);
      for (int k = 0; k < 150; k++)
        step(($urandom % 4) == 0, 1'($urandom), 1'($urandom));
      if (blk == 10) begin
        @(negedge tck); #1;
        do_reset();
      end
    end

    // R2 from random states
    for (int k = 0; k < 8; k++) begin
      repeat ($urandom % 9) step(1'($urandom), 1'($urandom), 1'b0);
      repeat (5) step(1'b1, 1'b0, 1'b0);
      check("R2 five ones from random state", {4'd0, tap_state}, 8'd0);
      check("R11 bypass after tms reset", {4'd0, ir_value}, {4'd0, OPB});
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule